// File: doc/BRIEF.md
# Load/Store Address Alignment Guard

This block sits between the execute stage of a 32-bit processor and its data memory port. Each cycle it may receive one access request: a virtual address, a size code, a direction flag, write data, a flag that marks the unaligned-word instructions (the left/right word loads and stores), and a valid strobe. It decides, in the same cycle, whether the access is naturally aligned for its size.

An aligned access goes to the memory port as it arrived, and a load is allowed to write its destination register. A misaligned access never reaches memory and its load writeback is cancelled. Instead the block raises a one-cycle exception request carrying a 5-bit cause code: one code for loads and another for stores. The full faulting address is also captured into a bad-address register, which the exception logic reads. Unaligned-word instructions first have their address forced down to a word boundary, so they can never fault.

Top module: `access_align_guard`

## Requirements
- R1: A byte access (size code 0) never faults and is always forwarded when valid.
- R2: A halfword access (size code 1) is legal only when address bit 0 is zero.
- R3: A word access (size code 2) is legal only when address bits 1:0 are both zero. Size code 3 is handled as a word.
- R4: When the unaligned-word flag is set, the forwarded address has bits 1:0 cleared, the forwarded size is word (code 2), and the access never faults, whatever the low address bits.
- R5: A misaligned read raises exc_valid with exc_code 4. A misaligned write raises exc_valid with exc_code 5. exc_code is 0 whenever exc_valid is low.
- R6: On a fault, mem_valid and load_wb_en are both low in that same cycle.
- R7: On an aligned valid request, mem_valid is high and the address, direction, size and write data reach the memory port unchanged. load_wb_en is high exactly for reads.
- R8: On the clock edge that ends a faulting cycle, bad_vaddr takes the full faulting address. At all other edges it keeps its value.
- R9: Reset clears bad_vaddr to zero.
- R10: With req_valid low, mem_valid, load_wb_en and exc_valid are all low, and bad_vaddr does not change.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Virtual address of the access |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 or 3 word |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_uaw | input | 1 | Marks an unaligned-word (left/right) instruction |
| req_wdata | input | 32 | Store data |
| mem_valid | output | 1 | Memory request strobe |
| mem_addr | output | 32 | Address sent to memory |
| mem_size | output | 2 | Size code sent to memory |
| mem_write | output | 1 | Direction sent to memory |
| mem_wdata | output | 32 | Store data sent to memory |
| load_wb_en | output | 1 | Permits the load's destination register write |
| exc_valid | output | 1 | One-cycle address-error exception request |
| exc_code | output | 5 | Exception cause: 4 for a load, 5 for a store, 0 when idle |
| bad_vaddr | output | 32 | Last captured faulting address |

## Verification
Alignment and fault decisions are combinational, so an error in the legality decode or the code selection shows up at mem_valid, load_wb_en and exc_code in the same cycle as the request. An error in the bad-address register shows up on bad_vaddr one edge after a fault, or as a value that drifts on a cycle without a fault. The bench keeps a shadow copy of that register, so a spurious capture or a missed capture is seen at the very next edge.

// File: rtl/align_guard_pkg.sv
package align_guard_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  localparam logic [CODE_W-1:0] CODE_NONE  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_LDERR = 5'd4;
  localparam logic [CODE_W-1:0] CODE_STERR = 5'd5;
endpackage

// File: rtl/guard_rst_sync.sv
module guard_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[g] <= 1'b0;
          else           chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[g] <= 1'b0;
          else           chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/align_detect.sv
module align_detect
  import align_guard_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_in,
  input  logic [1:0]    size_in,
  input  logic          uaw_in,
  output logic [AW-1:0] eff_addr,
  output logic [1:0]    eff_size,
  output logic          legal
);
  localparam int unsigned LOW_BITS = 2;

  always_comb begin
    if (uaw_in) begin
      eff_addr = {addr_in[AW-1:LOW_BITS], {LOW_BITS{1'b0}}};
      eff_size = SZ_WORD;
    end else begin
      eff_addr = addr_in;
      eff_size = size_in;
    end
  end

  always_comb begin
    unique case (acc_size_e'(eff_size))
      SZ_BYTE: legal = 1'b1;
      SZ_HALF: legal = ~eff_addr[0];
      default: legal = ~|eff_addr[LOW_BITS-1:0];
    endcase
  end

  // R4
  uaw_never_misaligned_chk: assert final (!uaw_in || legal);
endmodule

// File: rtl/fault_capture.sv
module fault_capture #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  output logic [AW-1:0] held_addr
);
  logic [AW-1:0] addr_d, addr_q;

  always_comb begin
    addr_d = addr_q;
    if (cap_en) addr_d = cap_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign held_addr = addr_q;

  // R8
  capture_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> held_addr == $past(cap_addr));
  // R8
  hold_without_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(held_addr));
endmodule

// File: rtl/access_align_guard.sv
module access_align_guard
  import align_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_uaw,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              load_wb_en,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic [ADDR_W-1:0] bad_vaddr
);
  logic rst_n_sync;
  logic aligned;
  logic fault;
  logic [ADDR_W-1:0] eff_addr;
  logic [1:0] eff_size;

  guard_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_sync)
  );

  align_detect #(.AW(ADDR_W)) i_detect (
    .addr_in (req_addr),
    .size_in (req_size),
    .uaw_in  (req_uaw),
    .eff_addr(eff_addr),
    .eff_size(eff_size),
    .legal   (aligned)
  );

  always_comb begin
    fault      = req_valid & ~aligned;
    mem_valid  = req_valid & aligned;
    mem_addr   = eff_addr;
    mem_size   = eff_size;
    mem_write  = req_write;
    mem_wdata  = req_wdata;
    load_wb_en = req_valid & aligned & ~req_write;
    exc_valid  = fault;
    if (!fault)         exc_code = CODE_NONE;
    else if (req_write) exc_code = CODE_STERR;
    else                exc_code = CODE_LDERR;
  end

  fault_capture #(.AW(ADDR_W)) i_capture (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cap_en   (fault),
    .cap_addr (req_addr),
    .held_addr(bad_vaddr)
  );

  // R6
  fault_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    exc_valid |-> !mem_valid && !load_wb_en);
  // R5
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    exc_valid |-> exc_code == (req_write ? CODE_STERR : CODE_LDERR));
  // R1
  byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_size == 2'd0 && !req_uaw) |-> !exc_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !req_valid |-> !mem_valid && !exc_valid && !load_wb_en);
  // R8
  top_capture_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    exc_valid |=> bad_vaddr == $past(req_addr));
endmodule

// File: tb/test_access_align_guard.sv
module test_access_align_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic        req_uaw;
  logic [31:0] req_wdata;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic        load_wb_en;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] bad_vaddr;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow_bad;

  always #4 clk = ~clk;

  access_align_guard i_access_align_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_uaw(req_uaw),
    .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_write(mem_write), .mem_wdata(mem_wdata),
    .load_wb_en(load_wb_en), .exc_valid(exc_valid), .exc_code(exc_code),
    .bad_vaddr(bad_vaddr)
  );

  function automatic logic exp_legal(logic [31:0] a, logic [1:0] s, logic u);
    if (u) return 1'b1;
    if (s == 2'd0) return 1'b1;
    if (s == 2'd1) return a[0] == 1'b0;
    return a[1:0] == 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [31:0] a, logic [1:0] s, logic w, logic u,
                       logic [31:0] d);
    logic lg, flt;
    @(negedge clk);
    req_valid = v; req_addr = a; req_size = s; req_write = w; req_uaw = u;
    req_wdata = d;
    #1;
    lg  = exp_legal(a, s, u);
    flt = v & ~lg;
    if (!v) begin
      chk("R10 mem_valid", {31'd0, mem_valid}, 32'd0);
      chk("R10 exc_valid", {31'd0, exc_valid}, 32'd0);
      chk("R10 load_wb_en", {31'd0, load_wb_en}, 32'd0);
    end else if (flt) begin
      chk("R6 mem_valid", {31'd0, mem_valid}, 32'd0);
      chk("R6 load_wb_en", {31'd0, load_wb_en}, 32'd0);
      chk("R5 exc_valid", {31'd0, exc_valid}, 32'd1);
      chk("R5 exc_code", {27'd0, exc_code}, w ? 32'd5 : 32'd4);
    end else begin
      chk(u ? "R4 mem_valid" : (s == 2'd0 ? "R1 mem_valid" : "R7 mem_valid"),
          {31'd0, mem_valid}, 32'd1);
      chk("R5 idle code", {27'd0, exc_code}, 32'd0);
      chk(u ? "R4 mem_addr" : "R7 mem_addr", mem_addr,
          u ? {a[31:2], 2'b00} : a);
      chk(u ? "R4 mem_size" : "R7 mem_size", {30'd0, mem_size},
          u ? 32'd2 : {30'd0, s});
      chk("R7 mem_write", {31'd0, mem_write}, {31'd0, w});
      chk("R7 mem_wdata", mem_wdata, d);
      chk("R7 load_wb_en", {31'd0, load_wb_en}, {31'd0, ~w});
    end
    if (v && !u && s == 2'd1) chk("R2 fault", {31'd0, exc_valid}, {31'd0, a[0]});
    if (v && !u && s[1])      chk("R3 fault", {31'd0, exc_valid}, {31'd0, |a[1:0]});
    @(posedge clk);
    if (flt) shadow_bad = a;
    #1;
    chk("R8 bad_vaddr", bad_vaddr, shadow_bad);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_uaw = 1'b0; req_wdata = '0;
    shadow_bad = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 reset bad_vaddr", bad_vaddr, 32'd0);
    chk("R10 reset mem_valid", {31'd0, mem_valid}, 32'd0);

    apply(1, 32'h0000_1003, 2'd0, 0, 0, 32'h11);   // R1 odd byte
    apply(1, 32'h0000_2001, 2'd1, 0, 0, 32'h22);   // R2 load fault
    apply(1, 32'h0000_2002, 2'd1, 1, 0, 32'h33);   // R2 legal store
    apply(1, 32'hFFFF_FFFE, 2'd2, 1, 0, 32'h44);   // R3 store fault
    apply(1, 32'h8000_0001, 2'd3, 0, 0, 32'h55);   // R3 alt word fault
    apply(1, 32'h8000_0004, 2'd2, 0, 0, 32'h66);   // R3 legal
    apply(1, 32'h1234_5677, 2'd2, 0, 1, 32'h77);   // R4 left/right
    apply(1, 32'h1234_5675, 2'd1, 1, 1, 32'h88);   // R4 store
    apply(0, 32'hDEAD_BEE1, 2'd2, 1, 0, 32'h99);   // R10 idle
    apply(1, 32'hDEAD_BEE1, 2'd2, 0, 0, 32'h99);   // R8 capture
    apply(0, 32'h0000_0003, 2'd1, 0, 0, 32'h0);    // R8 hold

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra;
      ra = $urandom;
      apply(($urandom % 8) != 0, ra, 2'($urandom % 4), 1'($urandom % 2),
            ($urandom % 6) == 0, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule